// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers the fourteen interrupt conditions of a serial port (transmit-side, receive-side, the clear-to-send modem line and the bus interface) into one sticky status register. An enable register masks that register, and the block drives one active-high, level-sensitive interrupt line. Software acknowledges a condition by writing a one to its status bit. Writing a zero leaves the bit as it is. The source logic for each condition sits outside the block and delivers a one-cycle pulse or a held level on `evt_i`. The one exception is the clear-to-send change event, which the block derives from the `cts_i` pin itself.

Two small state machines drive the sequencing. The clear-to-send tracker has the states CTS_UNPRIMED, CTS_LOW and CTS_HIGH:
- UNPRIMED moves to LOW or HIGH on the first cycle after reset, following `cts_i`, and raises no event.
- LOW moves to HIGH when `cts_i` is 1.
- HIGH moves to LOW when `cts_i` is 0.
- Each of these two transitions raises the change event.

The interrupt output machine has the states IRQ_IDLE and IRQ_ACTIVE:
- IDLE moves to ACTIVE when any enabled status bit is set.
- ACTIVE moves back to IDLE when none is set.

Status is written with `wr_sel_i`=0 and enable with `wr_sel_i`=1.

Top module: `uart_irq_status_ctrl`

## Requirements
- R1: Status bit positions, from bit 0 upward, are: transmit holding empty (0), receive holding full (1), transmit FIFO low (2), transmit FIFO empty (3), receive FIFO high (4), receive FIFO full (5), transmit underrun (6), receive overrun (7), parity error (8), framing error (9), CTS change (10), receive idle timeout (11), break finished (12), bus error (13). A 1 on `evt_i[k]` sets status bit k at the next clock edge, and the bit stays set after the input drops.
- R2: A write with `wr_sel_i`=0 clears every status bit whose `wr_data_i` bit is 1 and leaves the bits written 0 unchanged.
- R3: When an event and an acknowledge for the same bit arrive in the same cycle, the bit ends up set.
- R4: A write with `wr_sel_i`=1 loads the enable register with `wr_data_i`. The enable bits use the same positions as the status bits, and `enable_o` shows the register.
- R5: Status bits capture events whatever the enable register holds. Only the interrupt output is masked.
- R6: `irq_o` is high exactly when, one cycle earlier, some status bit and its enable bit were both 1.
- R7: `rx_pend_o` is the OR of status AND enable over bits 4, 5, 7, 8, 9 and 11. `tx_pend_o` is the same OR over bits 2, 3 and 6. Both are taken from the current register contents.
- R8: Any change of `cts_i` between consecutive cycles sets status bit 10. `cts_level_o` shows `cts_i` one cycle late. The first cycle after reset raises no change event.
- R9: After reset, status, enable, `irq_o`, both group outputs and `cts_level_o` are all 0.
- R10: `evt_i[10]` has no effect on status. A write to the enable register leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | Set conditions, one per status bit (bit 10 unused) |
| cts_i | input | 1 | Clear-to-send line, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects status (write-one-to-clear), 1 selects enable |
| wr_data_i | input | 14 | Write data |
| status_o | output | 14 | Status register |
| enable_o | output | 14 | Enable register |
| irq_o | output | 1 | Interrupt line, active high |
| rx_pend_o | output | 1 | An enabled receive-group bit is set |
| tx_pend_o | output | 1 | An enabled transmit-group bit is set |
| cts_level_o | output | 1 | Registered clear-to-send level |

## Verification
Every register in the block is visible at the ports, so a wrong bit of internal state shows up in `status_o` or `enable_o` on the cycle after the faulty edge. A wrong interrupt decision shows up on `irq_o` one cycle after that. A clear-to-send tracker in the wrong state either sets bit 10 when no change occurred or misses a real change, and it also shows a wrong `cts_level_o`, both on the very next cycle. The bench's reference model is compared against all six outputs on every clock, so any divergence is reported within one cycle of its cause.

// File: rtl/uisc_pkg.sv
package uisc_pkg;

    localparam int SRC_W = 14;

    localparam int BIT_TX_HOLD_EMPTY = 0;
    localparam int BIT_RX_HOLD_FULL  = 1;
    localparam int BIT_TX_LOW        = 2;
    localparam int BIT_TX_EMPTY      = 3;
    localparam int BIT_RX_HIGH       = 4;
    localparam int BIT_RX_FULL       = 5;
    localparam int BIT_TX_UNDER      = 6;
    localparam int BIT_RX_OVER       = 7;
    localparam int BIT_PAR_ERR       = 8;
    localparam int BIT_FRM_ERR       = 9;
    localparam int BIT_CTS_CHG       = 10;
    localparam int BIT_RX_IDLE_TMO   = 11;
    localparam int BIT_BRK_END       = 12;
    localparam int BIT_BUS_ERR       = 13;

    localparam logic [SRC_W-1:0] RX_GROUP_MASK =
        (SRC_W'(1) << BIT_RX_HIGH) | (SRC_W'(1) << BIT_RX_FULL) |
        (SRC_W'(1) << BIT_RX_OVER) | (SRC_W'(1) << BIT_PAR_ERR) |
        (SRC_W'(1) << BIT_FRM_ERR) | (SRC_W'(1) << BIT_RX_IDLE_TMO);

    localparam logic [SRC_W-1:0] TX_GROUP_MASK =
        (SRC_W'(1) << BIT_TX_LOW) | (SRC_W'(1) << BIT_TX_EMPTY) |
        (SRC_W'(1) << BIT_TX_UNDER);

    typedef enum logic [1:0] {
        CTS_UNPRIMED = 2'd0,
        CTS_LOW      = 2'd1,
        CTS_HIGH     = 2'd2
    } cts_state_t;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;

endpackage

// File: rtl/uisc_cts_fsm.sv
module uisc_cts_fsm
    import uisc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_i,
    output logic cts_chg_o,
    output logic cts_level_o
);

    cts_state_t state_q;
    cts_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTS_UNPRIMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cts_chg_o = 1'b0;
        unique case (state_q)
            CTS_UNPRIMED: begin
                state_d = cts_i ? CTS_HIGH : CTS_LOW;
            end
            CTS_LOW: begin
                if (cts_i) begin
                    state_d   = CTS_HIGH;
                    cts_chg_o = 1'b1;
                end
            end
            CTS_HIGH: begin
                if (!cts_i) begin
                    state_d   = CTS_LOW;
                    cts_chg_o = 1'b1;
                end
            end
            default: begin
                state_d = CTS_UNPRIMED;
            end
        endcase
    end

    always_comb begin
        cts_level_o = (state_q == CTS_HIGH);
    end

    AST_CTS_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CTS_UNPRIMED || cts_i) |=> (cts_level_o == $past(cts_i))); // R8

endmodule

// File: rtl/uisc_status_bank.sv
module uisc_status_bank #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] stat_o
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_i[gi]) begin
                bit_q <= 1'b1;
            end else if (clr_i[gi]) begin
                bit_q <= 1'b0;
            end
        end

        assign stat_o[gi] = bit_q;

        AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[gi] |=> stat_o[gi]); // R3

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[gi] && !set_i[gi]) |=> !stat_o[gi]); // R2

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[gi] && !set_i[gi]) |=> $stable(stat_o[gi])); // R2
    end

endmodule

// File: rtl/uisc_irq_fsm.sv
module uisc_irq_fsm
    import uisc_pkg::*;
#(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] stat_i,
    input  logic [WIDTH-1:0] en_i,
    output logic             irq_o
);

    irq_state_t state_q;
    irq_state_t state_d;
    logic       any_pend;

    always_comb begin
        any_pend = |(stat_i & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_pend)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!any_pend) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE);
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_i & en_i)) |=> irq_o); // R6

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_i & en_i)) |=> !irq_o); // R6

endmodule

// File: rtl/uart_irq_status_ctrl.sv
module uart_irq_status_ctrl
    import uisc_pkg::*;
#(
    parameter int N_SRC = uisc_pkg::SRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             cts_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic [N_SRC-1:0] status_o,
    output logic [N_SRC-1:0] enable_o,
    output logic             irq_o,
    output logic             rx_pend_o,
    output logic             tx_pend_o,
    output logic             cts_level_o
);

    localparam logic [N_SRC-1:0] CTS_BIT_MASK = N_SRC'(1) << BIT_CTS_CHG;

    logic             cts_chg;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] clr_vec;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] masked;

    uisc_cts_fsm u_cts (
        .clk         (clk),
        .rst_n       (rst_n),
        .cts_i       (cts_i),
        .cts_chg_o   (cts_chg),
        .cts_level_o (cts_level_o)
    );

    always_comb begin
        set_vec = (evt_i & ~CTS_BIT_MASK) | (cts_chg ? CTS_BIT_MASK : '0);
        clr_vec = (wr_en_i && !wr_sel_i) ? wr_data_i : '0;
    end

    uisc_status_bank #(.WIDTH(N_SRC)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (status_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en_i && wr_sel_i) begin
            en_q <= wr_data_i;
        end
    end

    assign enable_o = en_q;

    always_comb begin
        masked    = status_o & en_q;
        rx_pend_o = |(masked & RX_GROUP_MASK);
        tx_pend_o = |(masked & TX_GROUP_MASK);
    end

    uisc_irq_fsm #(.WIDTH(N_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (status_o),
        .en_i   (en_q),
        .irq_o  (irq_o)
    );

    AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> (enable_o == $past(wr_data_i))); // R4

    AST_EN_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i && !(|evt_i) && !cts_chg) |=> $stable(status_o)); // R10

    AST_EVT10_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_chg && !status_o[BIT_CTS_CHG]) |=> !status_o[BIT_CTS_CHG]); // R10

    AST_CTS_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cts_chg |=> status_o[BIT_CTS_CHG]); // R8

endmodule

// File: tb/uart_irq_status_ctrl_tb.sv
module uart_irq_status_ctrl_tb;

    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_i = '0;
    logic         cts_i = 1'b0;
    logic         wr_en_i = 1'b0;
    logic         wr_sel_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic [W-1:0] status_o, enable_o;
    logic         irq_o, rx_pend_o, tx_pend_o, cts_level_o;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    uart_irq_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cts_i(cts_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o),
        .rx_pend_o(rx_pend_o), .tx_pend_o(tx_pend_o), .cts_level_o(cts_level_o)
    );

    // Behavioural reference model
    int m_stat = 0, m_en = 0, m_irq = 0, m_cts = 0, m_primed = 0;
    bit model_live = 0;
    localparam int RXM = 32'h0BB0;
    localparam int TXM = 32'h004C;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_irq = 0; m_cts = 0; m_primed = 0;
        end else begin
            int ev, clr, nirq;
            ev = int'(evt_i) & ~(1 << 10);
            if (m_primed != 0 && int'(cts_i) != m_cts) ev = ev | (1 << 10);
            clr = (wr_en_i && !wr_sel_i) ? int'(wr_data_i) : 0;
            nirq = ((m_stat & m_en) != 0) ? 1 : 0;
            m_stat = (m_stat & ~clr) | ev;
            if (wr_en_i && wr_sel_i) m_en = int'(wr_data_i);
            m_irq = nirq;
            m_cts = int'(cts_i);
            m_primed = 1;
            model_live = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_live) begin
            chk("R1/R2/R3/R5/R10 status vs model", int'(status_o), m_stat);
            chk("R4 enable vs model", int'(enable_o), m_en);
            chk("R6 irq vs model", int'(irq_o), m_irq);
            chk("R7 rx_pend vs model", int'(rx_pend_o), ((m_stat & m_en & RXM) != 0) ? 1 : 0);
            chk("R7 tx_pend vs model", int'(tx_pend_o), ((m_stat & m_en & TXM) != 0) ? 1 : 0);
            chk("R8 cts_level vs model", int'(cts_level_o), m_cts);
        end
    end

    // One active cycle, then inputs return to idle at the next falling edge.
    task automatic apply(input logic [W-1:0] e, input logic w, input logic s, input logic [W-1:0] d);
        @(negedge clk);
        evt_i = e; wr_en_i = w; wr_sel_i = s; wr_data_i = d;
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r;
        r = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R9 status in reset", int'(status_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 status after reset", int'(status_o), 0);
        chk("R9 enable after reset", int'(enable_o), 0);
        chk("R9 irq after reset", int'(irq_o), 0);
        chk("R9 cts level after reset", int'(cts_level_o), 0);

        // R1: walk each source to its own bit, then acknowledge it (R2)
        for (int i = 0; i < W; i++) begin
            if (i != 10) begin
                apply(W'(1) << i, 1'b0, 1'b0, '0);
                chk("R1 single source position", int'(status_o), 1 << i);
                idle();
                chk("R1 bit sticks after pulse", int'(status_o), 1 << i);
                apply('0, 1'b1, 1'b0, W'(1) << i);
                chk("R2 ack clears", int'(status_o), 0);
            end
        end

        // R2: partial acknowledge
        apply(14'h23A5, 1'b0, 1'b0, '0);
        apply('0, 1'b1, 1'b0, 14'h0021);
        chk("R2 partial ack keeps zeros-written bits", int'(status_o), 32'h2384);
        apply('0, 1'b1, 1'b0, 14'h3FFF);
        chk("R2 full ack", int'(status_o), 0);

        // R3: collision
        apply(14'h0020, 1'b1, 1'b0, 14'h0020);
        chk("R3 event beats ack", int'(status_o), 32'h0020);

        // R5: capture while disabled, no interrupt
        apply(14'h1001, 1'b0, 1'b0, '0);
        idle();
        chk("R5 captured while disabled", int'(status_o), 32'h1021);
        chk("R5 irq masked", int'(irq_o), 0);

        // R10: enable write keeps status
        apply('0, 1'b1, 1'b1, 14'h0020);
        chk("R4 enable loads", int'(enable_o), 32'h0020);
        chk("R10 enable write leaves status", int'(status_o), 32'h1021);
        chk("R6 irq still low one cycle after enable", int'(irq_o), 0);
        idle();
        chk("R6 irq high after lag", int'(irq_o), 1);
        chk("R7 rx group pending", int'(rx_pend_o), 1);
        chk("R7 tx group idle", int'(tx_pend_o), 0);
        apply('0, 1'b1, 1'b0, 14'h0020);
        chk("R2 ack of enabled bit", int'(status_o), 32'h1001);
        chk("R6 irq lags clear", int'(irq_o), 1);
        idle();
        chk("R6 irq drops", int'(irq_o), 0);

        // R7: transmit group and out-of-group bit
        apply('0, 1'b1, 1'b1, 14'h3FFF);
        apply(14'h0008, 1'b0, 1'b0, '0);
        chk("R7 tx group pending", int'(tx_pend_o), 1);
        chk("R7 rx group not pending", int'(rx_pend_o), 0);
        apply('0, 1'b1, 1'b0, 14'h3FFF);
        chk("R7 tx clear", int'(tx_pend_o), 0);

        // R10: evt bit 10 ignored
        apply(14'h0400, 1'b0, 1'b0, '0);
        idle();
        chk("R10 evt bit10 ignored", int'(status_o), 0);

        // R8: CTS changes
        @(negedge clk); cts_i = 1'b1;
        @(negedge clk);
        chk("R8 rise sets change bit", int'(status_o), 32'h0400);
        chk("R8 level follows", int'(cts_level_o), 1);
        apply('0, 1'b1, 1'b0, 14'h0400);
        chk("R8 change acked", int'(status_o), 0);
        @(negedge clk); cts_i = 1'b0;
        @(negedge clk);
        chk("R8 fall sets change bit", int'(status_o), 32'h0400);
        apply('0, 1'b1, 1'b0, 14'h3FFF);

        // R8: no event on first cycle after reset with CTS high
        cts_i = 1'b1;
        rst_n = 1'b0;
        model_live = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 no change event after reset", int'(status_o), 0);
        chk("R8 level after reset", int'(cts_level_o), 1);

        // Mixed traffic, checked by the model on every cycle
        for (int n = 0; n < 3000; n++) begin
            r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
            @(negedge clk);
            evt_i     = W'(r) & W'(r >>> 14) & W'(r >>> 7);
            wr_en_i   = r[30] & r[29];
            wr_sel_i  = r[28] & r[27];
            wr_data_i = W'(r >>> 9);
            if (r[26] & r[25] & r[24]) cts_i = ~cts_i;
        end
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule